// File: doc/BRIEF.md
# Interleaving Two-Bank Address Mapper

This block sits between one system-bus request port and two DRAM controller ports. Every request address is compared against a handful of programmable section registers. A section that matches sends the request either to one fixed bank or, when interleaving is on, alternately to bank 0 and bank 1 in fixed-size granules. The block also works out the address local to the chosen bank. An address that no section covers is not forwarded: the requester gets a one-cycle error pulse instead.

Software writes the section registers through a small indexed port and can read every value back. A section with target code zero is switched off. This means an all-zero register disables its section. Requests use a valid/ready handshake. The ready of the chosen bank is returned to the requester unchanged.

Top module: `ilvmap_top`

## Requirements
- R1: After reset every section register reads 0 and no section matches, so any request gets the error response.
- R2: A value written to section register `cfg_idx` is returned on `cfg_rdata` one clock after `cfg_idx` selects that register. All 32 bits are kept as written.
- R3: Section register fields are: bits [31:24] base address bits [31:24]; bits [22:20] size code s, giving a size of 16 MB << s (16 MB to 2 GB); bits [17:16] granule code; bits [9:8] target (0 off, 1 bank 0, 2 bank 1, 3 interleaved). Address bits below the size are ignored when the base is compared.
- R4: A matching section with target 1 or 2 forwards the request to that bank only. The local address equals the address offset inside the section.
- R5: In an interleaved section the first granule goes to bank 0 and consecutive granules alternate. The bank is the offset bit just above the granule. The local address is the offset with that bit removed and the upper bits shifted down by one.
- R6: Granule code 0, 1 and 2 select 128, 256 and 512 bytes. Code 3 behaves as 512 bytes.
- R7: When several sections match, the lowest-numbered section decides the routing.
- R8: A request that matches no section asserts `err_valid` for exactly one cycle, in the cycle after it is presented. It drives neither bank valid, and it is accepted at once (`req_ready` = 1).
- R9: For a matching request, `req_ready` equals the ready input of the chosen bank. A stalled request stays presented to that bank.
- R10: A section whose target field is 0 never matches, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a section register |
| cfg_idx | input | 2 | Section register index for write and readback |
| cfg_wdata | input | 32 | Section register write value |
| cfg_rdata | output | 32 | Registered readback of section `cfg_idx` |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | Request is a write |
| b0_valid | output | 1 | Request valid toward bank 0 |
| b0_ready | input | 1 | Bank 0 ready |
| b0_addr | output | 32 | Bank 0 local address |
| b0_write | output | 1 | Bank 0 write flag |
| b1_valid | output | 1 | Request valid toward bank 1 |
| b1_ready | input | 1 | Bank 1 ready |
| b1_addr | output | 32 | Bank 1 local address |
| b1_write | output | 1 | Bank 1 write flag |
| err_valid | output | 1 | One-cycle error pulse for an unmapped request |

## Verification
The address patterns include two side-by-side single-bank sections, which check the bank choice and the offset arithmetic. They also include a 2 GB interleaved section walked across granule edges at each granule size, which separates the bank bit from the local-address shift. Overlapping sections with different targets show whether the priority order is applied. A disabled section with live base and size fields, and addresses outside every section, show that misses are never forwarded. Holding one bank's ready low shows whether the handshake follows the chosen bank rather than the other one.

// File: rtl/ilvmap_pkg.sv
package ilvmap_pkg;
  typedef enum logic [1:0] {
    TGT_OFF = 2'd0,
    TGT_B0  = 2'd1,
    TGT_B1  = 2'd2,
    TGT_ILV = 2'd3
  } tgt_e;

  localparam int REG_W     = 32;
  localparam int MIN_SZ_LG = 24;  // smallest section: 16 MB
  localparam int GRAN_LG0  = 7;   // smallest granule: 128 B

  typedef struct packed {
    logic [2:0] size_code;
    logic [1:0] gran_code;
    tgt_e       tgt;
  } route_t;
endpackage

// File: rtl/ilvmap_regs.sv
module ilvmap_regs #(
  parameter int NSEC = 4,
  localparam int IW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic [31:0] sec_q [NSEC]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEC; i++) sec_q[i] <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we) sec_q[cfg_idx] <= cfg_wdata;
      cfg_rdata <= sec_q[cfg_idx];
    end
  end

  // R2
  readback_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> sec_q[$past(cfg_idx)] == $past(cfg_wdata));
endmodule

// File: rtl/ilvmap_decode.sv
module ilvmap_decode
  import ilvmap_pkg::*;
#(
  parameter int NSEC = 4
) (
  input  logic [7:0]  addr_hi,
  input  logic [31:0] sec_q [NSEC],
  output logic        hit,
  output route_t      route
);
  logic [NSEC-1:0] match;
  logic [NSEC-1:0] unused_bits;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    logic [7:0] base;
    logic [7:0] mask;
    assign base = sec_q[g][31:24];
    assign mask = 8'hFF << sec_q[g][22:20];
    assign match[g] = (sec_q[g][9:8] != TGT_OFF) &&
                      (((addr_hi ^ base) & mask) == 8'h00);
    assign unused_bits[g] = ^{sec_q[g][23], sec_q[g][19:18],
                              sec_q[g][15:10], sec_q[g][7:0]};
  end

  always_comb begin
    hit   = 1'b0;
    route = '0;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit             = 1'b1;
        route.size_code = sec_q[i][22:20];
        route.gran_code = sec_q[i][17:16];
        route.tgt       = tgt_e'(sec_q[i][9:8]);
      end
    end
  end
endmodule

// File: rtl/ilvmap_route.sv
module ilvmap_route
  import ilvmap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hit,
  input  route_t            route,
  input  logic              b0_ready,
  input  logic              b1_ready,
  output logic              req_ready,
  output logic              b0_valid,
  output logic              b1_valid,
  output logic [ADDR_W-1:0] local_addr,
  output logic              err_valid
);
  logic [ADDR_W-1:0] offset, hi_part, lo_part;
  logic [4:0]        glg;
  logic              use_b1;

  always_comb begin
    offset  = req_addr & ~({ADDR_W{1'b1}} << (MIN_SZ_LG + int'(route.size_code)));
    glg     = 5'(GRAN_LG0) + ((route.gran_code == 2'd3) ? 5'd2 : 5'(route.gran_code));
    hi_part = (offset >> (glg + 5'd1)) << glg;
    lo_part = offset & ~({ADDR_W{1'b1}} << glg);
    case (route.tgt)
      TGT_ILV: begin
        use_b1     = offset[glg];
        local_addr = hi_part | lo_part;
      end
      TGT_B1: begin
        use_b1     = 1'b1;
        local_addr = offset;
      end
      default: begin
        use_b1     = 1'b0;
        local_addr = offset;
      end
    endcase
    b0_valid  = req_valid && hit && !use_b1;
    b1_valid  = req_valid && hit && use_b1;
    req_ready = !hit || (use_b1 ? b1_ready : b0_ready);
  end

  always_ff @(posedge clk) begin
    if (rst) err_valid <= 1'b0;
    else     err_valid <= req_valid && !hit;
  end

  // R4
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    !(b0_valid && b1_valid));
  // R8
  miss_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit) |=> err_valid);
  // R8
  miss_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit) |-> (!b0_valid && !b1_valid && req_ready));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (b1_valid && !b1_ready) |-> !req_ready);
endmodule

// File: rtl/ilvmap_top.sv
module ilvmap_top
  import ilvmap_pkg::*;
#(
  parameter int NSEC   = 4,
  parameter int ADDR_W = 32,
  localparam int IW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              b0_valid,
  input  logic              b0_ready,
  output logic [ADDR_W-1:0] b0_addr,
  output logic              b0_write,
  output logic              b1_valid,
  input  logic              b1_ready,
  output logic [ADDR_W-1:0] b1_addr,
  output logic              b1_write,
  output logic              err_valid
);
  logic [31:0]       sec_q [NSEC];
  logic              hit;
  route_t            route;
  logic [ADDR_W-1:0] local_addr;

  ilvmap_regs #(.NSEC(NSEC)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sec_q(sec_q)
  );

  ilvmap_decode #(.NSEC(NSEC)) u_dec (
    .addr_hi(req_addr[ADDR_W-1 -: 8]), .sec_q(sec_q), .hit(hit), .route(route)
  );

  ilvmap_route #(.ADDR_W(ADDR_W)) u_route (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .hit(hit), .route(route), .b0_ready(b0_ready), .b1_ready(b1_ready),
    .req_ready(req_ready), .b0_valid(b0_valid), .b1_valid(b1_valid),
    .local_addr(local_addr), .err_valid(err_valid)
  );

  assign b0_addr  = local_addr;
  assign b1_addr  = local_addr;
  assign b0_write = req_write;
  assign b1_write = req_write;

  // R10
  hit_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> route.tgt != TGT_OFF);
endmodule

// File: tb/tb_ilvmap_top.sv
`timescale 1ns/1ps
module tb_ilvmap_top;
  logic        clk = 0, rst = 1;
  logic        cfg_we = 0;
  logic [1:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_addr = 0;
  logic        b0_valid, b0_ready = 1, b0_write;
  logic        b1_valid, b1_ready = 1, b1_write;
  logic [31:0] b0_addr, b1_addr;
  logic        err_valid;

  int errors = 0, checks = 0;

  typedef struct { int kind; logic [31:0] addr; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  ilvmap_top dut (.*);

  function automatic logic [31:0] enc(input logic [7:0] base, input int sz,
                                      input int gr, input int tgt);
    return {base, 1'b0, 3'(sz), 2'b0, 2'(gr), 6'b0, 2'(tgt), 8'h00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] v);
    @(posedge clk); #1 cfg_we = 1; cfg_idx = 2'(idx); cfg_wdata = v;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    @(posedge clk); #1 cfg_idx = 2'(idx);
    @(negedge clk);
    @(negedge clk); chk(tag, cfg_rdata, exp);
  endtask

  // kind: 0 bank 0, 1 bank 1, 2 error
  task automatic send(input logic [31:0] a, input int kind,
                      input logic [31:0] la, input string tag);
    exp_t e;
    e.kind = kind; e.addr = la; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1 req_valid = 1; req_addr = a;
    @(posedge clk); #1 req_valid = 0;
    @(posedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && (((b0_valid || b1_valid) && req_ready) || err_valid)) begin
      int k;
      logic [31:0] la;
      k  = err_valid ? 2 : (b1_valid ? 1 : 0);
      la = err_valid ? 32'h0 : (b1_valid ? b1_addr : b0_addr);
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected output: actual kind=%0d addr=%h expected none", k, la);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " kind"}, 32'(k), 32'(e.kind));
        if (e.kind != 2) chk({e.tag, " addr"}, la, e.addr);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    rd(0, 32'h0, "R1 reg0");
    rd(3, 32'h0, "R1 reg3");
    send(32'h8000_0000, 2, 0, "R1 miss after reset");

    // R2 R3 R4 single-bank sections
    wr(0, enc(8'h80, 6, 0, 1));
    wr(1, enc(8'hC0, 6, 0, 2));
    rd(0, 32'h8060_0100, "R2 reg0");
    rd(1, 32'hC060_0200, "R2 reg1");
    send(32'h8000_1234, 0, 32'h0000_1234, "R4 bank0");
    send(32'hC123_4568, 1, 32'h0123_4568, "R4 bank1");
    send(32'h3000_0000, 2, 0, "R8 below sections");

    // R5 interleaved 128 B
    wr(0, 0); wr(1, 0);
    wr(2, enc(8'h80, 7, 0, 3));
    send(32'h8000_0000, 0, 32'h0000_0000, "R5 g0");
    send(32'h8000_0080, 1, 32'h0000_0000, "R5 g1");
    send(32'h8000_0100, 0, 32'h0000_0080, "R5 g2");
    send(32'h8000_01A4, 1, 32'h0000_00A4, "R5 g3");

    // R6 granule sizes
    wr(2, enc(8'h80, 7, 1, 3));
    send(32'h8000_0180, 1, 32'h0000_0080, "R6 256 b1");
    send(32'h8000_0280, 0, 32'h0000_0180, "R6 256 b0");
    wr(2, enc(8'h80, 7, 2, 3));
    send(32'h8000_0280, 1, 32'h0000_0080, "R6 512 a");
    send(32'h8000_0600, 1, 32'h0000_0200, "R6 512 b");
    wr(2, enc(8'h80, 7, 3, 3));
    send(32'h8000_0200, 1, 32'h0000_0000, "R6 code3");
    wr(2, enc(8'h80, 7, 2, 3));

    // R7 priority
    wr(0, enc(8'h80, 4, 0, 2));
    send(32'h8000_0080, 1, 32'h0000_0080, "R7 sec0 wins");
    send(32'h9000_0000, 0, 32'h0800_0000, "R7 falls to sec2");

    // R10 disabled section
    wr(3, enc(8'h00, 7, 1, 0));
    rd(3, 32'h0071_0000, "R2 reg3");
    send(32'h1000_0000, 2, 0, "R10 disabled");

    // R9 ready passthrough
    begin
      exp_t e;
      b1_ready = 0;
      e.kind = 1; e.addr = 32'h0000_0040; e.tag = "R9 stalled";
      sb.push_back(e);
      @(posedge clk); #1 req_valid = 1; req_addr = 32'h8000_0040;
      @(negedge clk); chk("R9 ready low", 32'(req_ready), 32'd0);
      chk("R9 b1 valid held", 32'(b1_valid), 32'd1);
      @(posedge clk); #1 b1_ready = 1;
      @(negedge clk); chk("R9 ready high", 32'(req_ready), 32'd1);
      @(posedge clk); #1 req_valid = 0;
      @(posedge clk);
    end

    // R8 error pulse length
    send(32'h7000_0000, 2, 0, "R8 miss");
    @(negedge clk); chk("R8 one cycle", 32'(err_valid), 32'd0);

    repeat (3) @(posedge clk);
    chk("scoreboard drained", 32'(sb.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule